// File: doc/BRIEF.md
# Pre-Classified RAM Ternary Lookup Engine

This block is a ternary search engine built from plain synchronous RAMs. The stored table is split offline into M sub-tables. Each sub-table occupies one row of V RAM blocks. In every RAM, each bit position stands for one entry slot of that row. A sub-word of the search key addresses the RAM. The bit read back tells whether that slot's ternary pattern accepts this slice of the key.

A pre-classifier picks log2(M) bits out of the key at runtime-programmable positions. It turns them into a one-hot row enable, so each lookup reads only one row of RAMs. The V words read from that row are ANDed together. A priority encoder then picks the lowest matching slot. A per-row slot map translates that slot into a global table address.

The engine accepts one key per clock behind a valid strobe. The result appears three cycles later with its own valid. Table contents and slot maps are written through a simple write port by an external loader.

Top module: `prc_ternary_search`

## Requirements
- R1: While reset is held and after its release, out_valid, match_hit and match_addr are all zero until a key result emerges.
- R2: A key taken with key_valid at a rising edge produces out_valid high exactly three rising edges later. Keys may arrive on every cycle, and each yields exactly one result in order.
- R3: Classification bit j is key[sel_pos[j*PW +: PW]]. Bit 0 is the least significant bit of the selected row index.
- R4: Only the row chosen by R3 is read, and no row is read without key_valid. The contents of other rows have no effect on the result.
- R5: Sub-word v is key[v*SW +: SW] and addresses block v of the selected row. Slot s matches when bit s is set in the word read from every block.
- R6: When several slots of the selected row match, the lowest-numbered slot wins.
- R7: When no slot matches, match_hit is low and match_addr is zero while out_valid is high.
- R8: On a hit, match_addr is the value last written to the slot map at (selected row, winning slot).
- R9: A new sel_pos value takes effect for the next key presented. A table reloaded for new positions gives correct results under them.
- R10: A write with wr_en stores wr_bits at address wr_addr of block wr_blk in row wr_row. Bit s of that word is slot s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_pos | input | CBW*PW | Classification bit positions, field j selects row-index bit j |
| key_valid | input | 1 | Key strobe |
| key | input | W | Search key |
| wr_en | input | 1 | RAM word write strobe |
| wr_row | input | CBW | Row of the RAM write |
| wr_blk | input | VBW | Block of the RAM write |
| wr_addr | input | SW | Address of the RAM write |
| wr_bits | input | S | Slot bits to store |
| map_we | input | 1 | Slot map write strobe |
| map_row | input | CBW | Row of the slot map write |
| map_slot | input | SLW | Slot of the slot map write |
| map_gaddr | input | GAW | Global address for that slot |
| out_valid | output | 1 | Result valid |
| match_hit | output | 1 | A slot matched |
| match_addr | output | GAW | Global address of the winning slot, zero on a miss |

## Verification
The hardest case to reach from the ports is proving that rows other than the selected one cannot influence a result. With a correctly partitioned table, a leak from another row would often produce the same answer anyway. The stimulus therefore loads a consistent table and then plants a catch-all pattern in the spare last slot of one row, with a distinctive global address. Keys aimed at that row must miss into the planted slot, or lose it to a lower real slot. Keys aimed at other rows must keep the answers of a plain ternary scan of the whole table.

// File: rtl/tsrch_pkg.sv
`timescale 1ns/1ps
// Shared defaults for the pre-classified ternary lookup engine.
// Assumes key width equals blocks-per-row times log2 of RAM depth.
package tsrch_pkg;
    localparam int unsigned DEF_W   = 16;  // key width
    localparam int unsigned DEF_V   = 4;   // RAM blocks per row
    localparam int unsigned DEF_RD  = 16;  // RAM depth
    localparam int unsigned DEF_M   = 4;   // rows (sub-tables)
    localparam int unsigned DEF_S   = 16;  // slots per row (RAM word width)
    localparam int unsigned DEF_GAW = 6;   // global address width
endpackage

// File: rtl/tsrch_preclass.sv
`timescale 1ns/1ps
// Pre-classifier: picks CBW key bits at programmable positions and
// decodes them into a one-hot row read enable, gated by key_valid.
// Assumes every sel_pos field is below W.
module tsrch_preclass #(
    parameter int unsigned W   = 16,
    parameter int unsigned M   = 4,
    parameter int unsigned CBW = $clog2(M),
    parameter int unsigned PW  = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     key,
    input  logic [CBW*PW-1:0] sel_pos,
    input  logic             key_valid,
    output logic [CBW-1:0]   row_idx,
    output logic [M-1:0]     row_en
);
    // one multiplexer per classification bit
    for (genvar j = 0; j < CBW; j++) begin : g_mux
        assign row_idx[j] = key[sel_pos[j*PW +: PW]];
    end

    // decode the extracted bits into a single row enable
    always_comb begin
        row_en = '0;
        if (key_valid) row_en[row_idx] = 1'b1;
    end

    // R4
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_en));
    // R4
    row_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |-> (row_en == '0));
endmodule

// File: rtl/tsrch_ram.sv
`timescale 1ns/1ps
// One synchronous RAM block: word = one bit per slot of its row.
// Registered read only when enabled; the loader never writes and
// reads the same block in one cycle.
module tsrch_ram #(
    parameter int unsigned RD = 16,
    parameter int unsigned S  = 16,
    parameter int unsigned AW = $clog2(RD)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [S-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [S-1:0]  rdata
);
    logic [S-1:0] mem [RD];

    // write port and enabled registered read
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/tsrch_prio.sv
`timescale 1ns/1ps
// Priority encoder: lowest set bit of the match vector wins.
// Slot output is zero when no bit is set.
module tsrch_prio #(
    parameter int unsigned S   = 16,
    parameter int unsigned SLW = $clog2(S)
) (
    input  logic [S-1:0]   vec,
    output logic           hit,
    output logic [SLW-1:0] slot
);
    // scan from the top so the lowest set bit is written last
    always_comb begin
        slot = '0;
        for (int i = S - 1; i >= 0; i--) begin
            if (vec[i]) slot = SLW'(i);
        end
        hit = |vec;
    end

    // R6
    always_comb begin
        if (hit) begin
            prio_lowest_chk: assert (vec[slot] &&
                ((vec & ((S'(1) << slot) - S'(1))) == '0));
        end
    end
endmodule

// File: rtl/prc_ternary_search.sv
`timescale 1ns/1ps
// Pre-classified ternary lookup: one RAM row enabled per key, V
// sub-word reads ANDed, lowest slot encoded, mapped to a global
// address. Three-stage pipeline, one key per cycle.
// Assumes W == V*log2(RD) and that the loader keeps each row consistent
// with the classification positions in use.
module prc_ternary_search #(
    parameter int unsigned W   = tsrch_pkg::DEF_W,
    parameter int unsigned V   = tsrch_pkg::DEF_V,
    parameter int unsigned RD  = tsrch_pkg::DEF_RD,
    parameter int unsigned M   = tsrch_pkg::DEF_M,
    parameter int unsigned S   = tsrch_pkg::DEF_S,
    parameter int unsigned GAW = tsrch_pkg::DEF_GAW,
    localparam int unsigned SW  = $clog2(RD),
    localparam int unsigned CBW = $clog2(M),
    localparam int unsigned PW  = $clog2(W),
    localparam int unsigned VBW = (V > 1) ? $clog2(V) : 1,
    localparam int unsigned SLW = $clog2(S)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CBW*PW-1:0] sel_pos,
    input  logic              key_valid,
    input  logic [W-1:0]      key,
    input  logic              wr_en,
    input  logic [CBW-1:0]    wr_row,
    input  logic [VBW-1:0]    wr_blk,
    input  logic [SW-1:0]     wr_addr,
    input  logic [S-1:0]      wr_bits,
    input  logic              map_we,
    input  logic [CBW-1:0]    map_row,
    input  logic [SLW-1:0]    map_slot,
    input  logic [GAW-1:0]    map_gaddr,
    output logic              out_valid,
    output logic              match_hit,
    output logic [GAW-1:0]    match_addr
);
    logic [CBW-1:0] row_idx;
    logic [M-1:0]   row_en;
    logic [S-1:0]   rd_word [M][V];

    tsrch_preclass #(.W(W), .M(M), .CBW(CBW), .PW(PW)) u_cls (
        .clk(clk), .rst_n(rst_n), .key(key), .sel_pos(sel_pos),
        .key_valid(key_valid), .row_idx(row_idx), .row_en(row_en)
    );

    // RAM array: M rows of V blocks
    for (genvar m = 0; m < M; m++) begin : g_row
        for (genvar v = 0; v < V; v++) begin : g_blk
            logic blk_we;
            assign blk_we = wr_en && (wr_row == CBW'(m)) && (wr_blk == VBW'(v));
            tsrch_ram #(.RD(RD), .S(S), .AW(SW)) u_ram (
                .clk(clk), .we(blk_we), .waddr(wr_addr), .wdata(wr_bits),
                .re(row_en[m]), .raddr(key[v*SW +: SW]),
                .rdata(rd_word[m][v])
            );
        end
    end

    // stage 1: track valid and row alongside the RAM read
    logic           v1;
    logic [CBW-1:0] row1;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1   <= 1'b0;
            row1 <= '0;
        end else begin
            v1   <= key_valid;
            row1 <= row_idx;
        end
    end

    // AND-reduce the V words of the row that was read
    logic [S-1:0] and_vec;
    always_comb begin
        and_vec = '1;
        for (int v = 0; v < V; v++) and_vec &= rd_word[row1][v];
    end

    logic           enc_hit;
    logic [SLW-1:0] enc_slot;
    tsrch_prio #(.S(S), .SLW(SLW)) u_prio (
        .vec(and_vec), .hit(enc_hit), .slot(enc_slot)
    );

    // stage 2: register the encoded winner
    logic           v2, hit2;
    logic [SLW-1:0] slot2;
    logic [CBW-1:0] row2;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2 <= 1'b0; hit2 <= 1'b0; slot2 <= '0; row2 <= '0;
        end else begin
            v2    <= v1;
            hit2  <= v1 && enc_hit;
            slot2 <= enc_slot;
            row2  <= row1;
        end
    end

    // per-row slot to global address map
    logic [GAW-1:0] slot_map [M][S];
    always_ff @(posedge clk) begin
        if (map_we) slot_map[map_row][map_slot] <= map_gaddr;
    end

    // stage 3: registered result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; match_hit <= 1'b0; match_addr <= '0;
        end else begin
            out_valid  <= v2;
            match_hit  <= v2 && hit2;
            match_addr <= (v2 && hit2) ? slot_map[row2][slot2] : '0;
        end
    end

    // cycles since reset, saturating, for the latency check window
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2
    out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(key_valid, 3)));
    // R7
    miss_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !match_hit) |-> (match_addr == '0));
    // R2
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |-> out_valid);
endmodule

// File: tb/prc_ternary_search_tb_top.sv
`timescale 1ns/1ps
// Bench: loads a ternary table partitioned by the chosen positions,
// walks a key table and a back-to-back stream against a plain ternary
// scan, then directed latency, reset and row-isolation tests.
module prc_ternary_search_tb_top;
    localparam int W = 16, V = 4, RD = 16, M = 4, S = 16, GAW = 6;
    localparam int SW = 4, CBW = 2, PW = 4, VBW = 2, SLW = 4;
    localparam int NE = 12;
    // {value, care}; care bit 1 = compared
    localparam logic [31:0] ENT [NE] = '{
        {16'h1234, 16'hFFFF}, {16'h1200, 16'hFF00}, {16'hA5A5, 16'hFFFF},
        {16'hA500, 16'hFF00}, {16'h00F0, 16'h00F0}, {16'hBEEF, 16'hFFF0},
        {16'h8000, 16'h8001}, {16'h5555, 16'h0F0F}, {16'hC3C3, 16'hFFFF},
        {16'h0001, 16'hF00F}, {16'h7777, 16'h7777}, {16'hFFFF, 16'hFFFF}};
    localparam int NK = 16;
    localparam logic [15:0] KEYS [NK] = '{
        16'h1234, 16'h12AB, 16'hA5A5, 16'hA512, 16'h00F0, 16'hBEE3,
        16'h8002, 16'h1535, 16'hC3C3, 16'h0001, 16'h0000, 16'hFFFF,
        16'h7777, 16'hF777, 16'h4321, 16'h9999};

    logic clk = 1'b0, rst_n = 1'b0;
    logic [CBW*PW-1:0] sel_pos = '0;
    logic key_valid = 1'b0;
    logic [W-1:0] key = '0;
    logic wr_en = 1'b0, map_we = 1'b0;
    logic [CBW-1:0] wr_row = '0, map_row = '0;
    logic [VBW-1:0] wr_blk = '0;
    logic [SW-1:0] wr_addr = '0;
    logic [S-1:0] wr_bits = '0;
    logic [SLW-1:0] map_slot = '0;
    logic [GAW-1:0] map_gaddr = '0;
    logic out_valid, match_hit;
    logic [GAW-1:0] match_addr;

    prc_ternary_search dut_i (
        .clk(clk), .rst_n(rst_n), .sel_pos(sel_pos), .key_valid(key_valid),
        .key(key), .wr_en(wr_en), .wr_row(wr_row), .wr_blk(wr_blk),
        .wr_addr(wr_addr), .wr_bits(wr_bits), .map_we(map_we),
        .map_row(map_row), .map_slot(map_slot), .map_gaddr(map_gaddr),
        .out_valid(out_valid), .match_hit(match_hit), .match_addr(match_addr));

    always #4 clk = ~clk;

    int errors = 0, checks = 0;
    int cnt [M];
    int slot_ent [M][S];
    logic [GAW:0] expq [$];
    logic mon_on = 1'b0;
    int n_sent = 0, n_got = 0;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // plain ternary scan, lowest global index first
    function automatic logic [GAW:0] ref_lookup(input logic [15:0] k);
        for (int i = 0; i < NE; i++)
            if (((k ^ ENT[i][31:16]) & ENT[i][15:0]) == 16'h0)
                return {1'b1, GAW'(i)};
        return '0;
    endfunction

    function automatic bit fits(input int e, input int r, input int p0, input int p1);
        for (int j = 0; j < 2; j++) begin
            int p = (j == 0) ? p0 : p1;
            if (ENT[e][p] && (ENT[e][16 + p] != r[j])) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [S-1:0] row_word(input int r, input int v, input int a);
        logic [S-1:0] w = '0;
        for (int s = 0; s < cnt[r]; s++) begin
            int e = slot_ent[r][s];
            logic [3:0] vs = ENT[e][16 + v*4 +: 4];
            logic [3:0] cs = ENT[e][v*4 +: 4];
            if (((4'(a) ^ vs) & cs) == 4'h0) w[s] = 1'b1;
        end
        return w;
    endfunction

    // partition, write all RAM words (R10) and slot maps (R8)
    task automatic load_table(input int p0, input int p1);
        sel_pos = {4'(p1), 4'(p0)};
        for (int r = 0; r < M; r++) begin
            cnt[r] = 0;
            for (int i = 0; i < NE; i++)
                if (fits(i, r, p0, p1)) begin slot_ent[r][cnt[r]] = i; cnt[r]++; end
        end
        for (int r = 0; r < M; r++)
            for (int v = 0; v < V; v++)
                for (int a = 0; a < RD; a++) begin
                    @(negedge clk);
                    wr_en = 1'b1; wr_row = 2'(r); wr_blk = 2'(v);
                    wr_addr = 4'(a); wr_bits = row_word(r, v, a);
                end
        @(negedge clk); wr_en = 1'b0;
        for (int r = 0; r < M; r++)
            for (int s = 0; s < cnt[r]; s++) begin
                @(negedge clk);
                map_we = 1'b1; map_row = 2'(r); map_slot = 4'(s);
                map_gaddr = GAW'(slot_ent[r][s]);
            end
        @(negedge clk); map_we = 1'b0;
    endtask

    task automatic send_exp(input logic [15:0] k, input logic [GAW:0] e);
        @(negedge clk);
        key_valid = 1'b1; key = k;
        expq.push_back(e); n_sent++;
    endtask

    task automatic drain();
        @(negedge clk); key_valid = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // result monitor: compares each valid result with the queued expectation
    always @(negedge clk) begin
        if (mon_on && out_valid) begin
            logic [GAW:0] e;
            n_got++;
            if (expq.size() == 0) check("R2 unexpected result", 32'(out_valid), 32'd0);
            else begin
                e = expq.pop_front();
                if (e[GAW]) check("R5 R6 R8 hit result", {match_hit, match_addr}, e);
                else check("R7 miss result", {match_hit, match_addr}, e);
            end
        end
    end

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid in reset", 32'(out_valid), 0);
        check("R1 hit in reset", 32'(match_hit), 0);
        check("R1 addr in reset", 32'(match_addr), 0);
        @(negedge clk); rst_n = 1'b1;
        load_table(3, 12);
        check("R1 valid after reset", 32'(out_valid), 0);
        check("R1 addr after reset", 32'(match_addr), 0);

        // R2: exact latency of a single key
        @(negedge clk); key_valid = 1'b1; key = 16'h1234;
        @(negedge clk); key_valid = 1'b0;
        check("R2 one edge", 32'(out_valid), 0);
        @(negedge clk); check("R2 two edges", 32'(out_valid), 0);
        @(negedge clk); check("R2 three edges", 32'(out_valid), 1);
        check("R6 priority 1234", {match_hit, match_addr}, {1'b1, 6'd0});
        @(negedge clk); check("R2 four edges", 32'(out_valid), 0);

        mon_on = 1'b1;
        // key table walk (R3 R5 R6 R7 R8)
        for (int i = 0; i < NK; i++) send_exp(KEYS[i], ref_lookup(KEYS[i]));
        drain();
        // back-to-back stream (R2)
        for (int i = 0; i < 200; i++) begin
            logic [15:0] k;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            k = (i % 2 == 0) ? KEYS[(i / 2) % NK] : lf;
            send_exp(k, ref_lookup(k));
        end
        drain();
        check("R2 result count", 32'(n_got), 32'(n_sent));

        // R4: plant catch-all slot 15 in row 0 with global address 63
        for (int v = 0; v < V; v++)
            for (int a = 0; a < RD; a++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_row = 2'd0; wr_blk = 2'(v);
                wr_addr = 4'(a); wr_bits = row_word(0, v, a) | 16'h8000;
            end
        @(negedge clk); wr_en = 1'b0;
        map_we = 1'b1; map_row = 2'd0; map_slot = 4'd15; map_gaddr = 6'd63;
        @(negedge clk); map_we = 1'b0;
        send_exp(16'h4321, {1'b1, 6'd63});   // R3 R4 row 0 selected
        send_exp(16'h9999, 7'd0);            // R4 row 3 untouched, miss
        send_exp(16'h1234, {1'b1, 6'd0});    // R4 row 2 untouched
        send_exp(16'h00F0, {1'b1, 6'd4});    // R6 real slot beats slot 15
        drain();

        // R9: new positions, reloaded table
        load_table(0, 15);
        for (int i = 0; i < NK; i++) send_exp(KEYS[i], ref_lookup(KEYS[i]));
        for (int i = 0; i < 60; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            send_exp(lf, ref_lookup(lf));
        end
        drain();
        check("R9 result count", 32'(n_got), 32'(n_sent));
        check("R2 queue empty", 32'(expq.size()), 0);

        // R1: reset mid-stream clears outputs
        @(negedge clk); key_valid = 1'b1; key = 16'h1234; rst_n = 1'b0; mon_on = 1'b0;
        @(negedge clk); key_valid = 1'b0;
        @(negedge clk);
        check("R1 valid on re-reset", 32'(out_valid), 0);
        check("R1 hit on re-reset", 32'(match_hit), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule